// File: doc/BRIEF.md
# Link Detect-Phase Sequencer

This block runs the detect phase of link training for a four-lane serial controller. It alternates between a quiet wait state and an active state that asks the PHY to probe for a far-end receiver. In the quiet state it waits either for the 12 ms timeout or for an assigned lane to report that it has left electrical idle. A software-set minimum dwell applies on top of that: an early idle exit cannot end the quiet wait before the dwell has run. This keeps the transmit lines from being probed again before they have discharged.

A lane mask names the lanes that belong to the link. Unassigned lanes are treated as idle and as having found no receiver, whatever the PHY reports on them. When a probe finds a receiver on an assigned lane, the sequencer raises a detect-complete flag and latches which lanes answered. It holds there until a restart request sends it back to the quiet state. The dwell length comes from a two-bit field in a 32-bit control word, written through a single write port. All durations are counted in clock cycles derived from the CLK_KHZ parameter, which a test bench may scale down.

Top module: `linkdet_seq`

## Requirements
- R1: In the quiet state, an assigned lane with its electrical-idle bit low ends the wait once the minimum dwell is met. An exit seen on quiet cycle n (counting from 1) at or after the dwell moves the sequencer to the detect request on the next cycle, so the quiet state lasts exactly n cycles.
- R2: The minimum-dwell field is control bits [2:1]. Code 0 means no minimum, 1 means CLK_KHZ/2 cycles (0.5 ms), 2 means CLK_KHZ cycles (1 ms) and 3 means 2*CLK_KHZ cycles (2 ms). With minimum m, an idle exit present earlier keeps the quiet state for exactly m+1 cycles.
- R3: With no qualifying idle exit, the quiet state lasts exactly 12*CLK_KHZ cycles and never longer.
- R4: Leaving the quiet state produces a detect request (rxDetReq) that is high for exactly one cycle, after which the sequencer waits for rxDetDone.
- R5: If rxDetDone arrives with no assigned lane set in rxDetFound, the sequencer goes back to the quiet state and applies the full quiet rules again. Two consecutive detect requests are therefore always at least m+3 cycles apart.
- R6: Lanes whose laneMask bit is 0 count as idle and as not detected. They can neither end the quiet wait nor make a probe succeed, and they never appear in detLanes.
- R7: A write replaces only the dwell field. A read returns the field at bits [2:1] and zero in every other bit.
- R8: Reset enters the quiet state with the quiet timer at zero. After reset, rxDetReq and detComplete are 0, detLanes is 0 and the dwell field is 0.
- R9: On rxDetDone with at least one assigned lane found, detComplete rises and detLanes latches rxDetFound & laneMask. Both hold until linkRestart, which returns the sequencer to the quiet state on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control-word write strobe |
| regWrData | input | 32 | Control-word write data; only bits [2:1] are kept |
| regRdData | output | 32 | Control-word read value |
| laneMask | input | LANES | 1 marks a lane that belongs to the link |
| elecIdle | input | LANES | Per-lane electrical-idle status from the PHY (1 = idle) |
| rxDetDone | input | 1 | PHY strobe: the receiver probe has finished |
| rxDetFound | input | LANES | Per-lane probe result, valid with rxDetDone |
| linkRestart | input | 1 | Leave detect-complete and start over in the quiet state |
| rxDetReq | output | 1 | One-cycle receiver-probe request |
| quietActive | output | 1 | High while in the quiet state |
| detComplete | output | 1 | A receiver was found; training may proceed |
| detLanes | output | LANES | Assigned lanes on which a receiver was found |

## Verification
The bench sends an idle exit early in the quiet wait and expects it to be held until the programmed dwell has passed. A design that honours the exit at once would probe after a few cycles. The bench drives non-idle status and positive probe results on unassigned lanes and expects a full timeout and a failed probe. A design without the mask would leave the wait early or report a false link. After a failed probe it measures the second quiet wait, which catches a design that jumps straight back into probing. It also checks that a write with every other bit set leaves only the field visible, and that a reset in the middle of a run clears the latched lanes and the field.

// File: rtl/linkdet_pkg.sv
package linkdet_pkg;
  localparam int CTRL_W = 32;
  localparam int DWELL_LSB = 1;

  typedef enum logic [1:0] {
    ST_QUIET = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } detState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic inQuiet;
    logic latchLanes;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic exitSeen;
    logic minMet;
    logic timedOut;
    logic anyFound;
  } dpStat_t;
endpackage

// File: rtl/linkdet_dpath.sv
module linkdet_dpath
  import linkdet_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int CLK_KHZ = 100000,
  parameter int CW      = $clog2(12 * CLK_KHZ + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctl,
  output dpStat_t             stat,
  input  logic                regWrEn,
  input  logic [CTRL_W-1:0]   regWrData,
  output logic [CTRL_W-1:0]   regRdData,
  input  logic [LANES-1:0]    laneMask,
  input  logic [LANES-1:0]    elecIdle,
  input  logic [LANES-1:0]    rxDetFound,
  output logic [LANES-1:0]    detLanes,
  output logic [CW-1:0]       minCyc
);
  localparam int TMO_CYC  = 12 * CLK_KHZ;
  localparam int HALF_CYC = CLK_KHZ / 2;

  logic [1:0]    dwellField;
  logic [CW-1:0] quietCnt;
  logic          unusedWrBits;

  assign unusedWrBits = ^{regWrData[CTRL_W-1:DWELL_LSB+2], regWrData[DWELL_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) dwellField <= '0;
    else if (regWrEn) dwellField <= regWrData[DWELL_LSB+1:DWELL_LSB];
  end

  always_comb begin
    regRdData = '0;
    regRdData[DWELL_LSB+1:DWELL_LSB] = dwellField;
  end

  always_comb begin
    case (dwellField)
      2'd1:    minCyc = CW'(HALF_CYC);
      2'd2:    minCyc = CW'(CLK_KHZ);
      2'd3:    minCyc = CW'(2 * CLK_KHZ);
      default: minCyc = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) quietCnt <= '0;
    else if (!ctl.inQuiet) quietCnt <= '0;
    else if (quietCnt < CW'(TMO_CYC - 1)) quietCnt <= quietCnt + 1'b1;
  end

  assign stat.exitSeen = |(~elecIdle & laneMask);
  assign stat.minMet   = quietCnt >= minCyc;
  assign stat.timedOut = quietCnt == CW'(TMO_CYC - 1);
  assign stat.anyFound = |(rxDetFound & laneMask);

  always_ff @(posedge clk) begin
    if (!rstN) detLanes <= '0;
    else if (ctl.latchLanes) detLanes <= rxDetFound & laneMask;
  end

  // R3: quiet timer never runs past the timeout
  a_r3_timeout_bound: assert property (@(posedge clk) disable iff (!rstN)
    ctl.inQuiet |-> (int'(quietCnt) < TMO_CYC));
  // R7: the field changes only on a write
  a_r7_field_hold: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(dwellField));
endmodule

// File: rtl/linkdet_ctrl.sv
module linkdet_ctrl
  import linkdet_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStat_t   stat,
  input  logic      rxDetDone,
  input  logic      linkRestart,
  output dpCtrl_t   ctl,
  output detState_t state,
  output logic      rxDetReq,
  output logic      detComplete
);
  detState_t nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_QUIET: if (stat.timedOut || (stat.exitSeen && stat.minMet)) nextState = ST_REQ;
      ST_REQ:   nextState = ST_WAIT;
      ST_WAIT:  if (rxDetDone) nextState = stat.anyFound ? ST_DONE : ST_QUIET;
      ST_DONE:  if (linkRestart) nextState = ST_QUIET;
      default:  nextState = ST_QUIET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_QUIET;
    else state <= nextState;
  end

  assign ctl.inQuiet    = state == ST_QUIET;
  assign ctl.latchLanes = (state == ST_WAIT) && rxDetDone && stat.anyFound;
  assign rxDetReq       = state == ST_REQ;
  assign detComplete    = state == ST_DONE;

  // R4: probe request lasts one cycle
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxDetReq |=> !rxDetReq);
  // R2: an idle exit before the dwell is met keeps the quiet state
  a_r2_min_dwell: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inQuiet && stat.exitSeen && !stat.minMet && !stat.timedOut) |=> ctl.inQuiet);
  // R9: complete holds until restart
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (detComplete && !linkRestart) |=> detComplete);
endmodule

// File: rtl/linkdet_seq.sv
module linkdet_seq
  import linkdet_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int CLK_KHZ = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [LANES-1:0]  laneMask,
  input  logic [LANES-1:0]  elecIdle,
  input  logic              rxDetDone,
  input  logic [LANES-1:0]  rxDetFound,
  input  logic              linkRestart,
  output logic              rxDetReq,
  output logic              quietActive,
  output logic              detComplete,
  output logic [LANES-1:0]  detLanes
);
  localparam int CW = $clog2(12 * CLK_KHZ + 1);

  dpCtrl_t   ctl;
  dpStat_t   stat;
  detState_t state;
  logic [CW-1:0] minCyc;

  linkdet_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .rxDetDone(rxDetDone),
    .linkRestart(linkRestart), .ctl(ctl), .state(state),
    .rxDetReq(rxDetReq), .detComplete(detComplete)
  );

  linkdet_dpath #(.LANES(LANES), .CLK_KHZ(CLK_KHZ), .CW(CW)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .laneMask(laneMask), .elecIdle(elecIdle), .rxDetFound(rxDetFound),
    .detLanes(detLanes), .minCyc(minCyc)
  );

  assign quietActive = state == ST_QUIET;

  // independent spacing monitor for probe requests
  int   gapCnt;
  logic seenReq;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt  <= 0;
      seenReq <= 1'b0;
    end else begin
      if (rxDetReq) begin
        gapCnt  <= 1;
        seenReq <= 1'b1;
      end else if (gapCnt < 32'h3FFF_FFFF) begin
        gapCnt <= gapCnt + 1;
      end
    end
  end

  // R5: back-to-back probes are separated by at least the dwell plus three cycles
  a_r5_probe_gap: assert property (@(posedge clk) disable iff (!rstN)
    (rxDetReq && seenReq) |-> (gapCnt >= int'(minCyc) + 3));
  // R6: latched lanes never include an unassigned lane
  a_r6_lane_subset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detComplete) |-> ((detLanes & ~laneMask) == '0));
endmodule

// File: tb/test_linkdet_seq.sv
module test_linkdet_seq;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ = 40;
  localparam int TMO = 12 * KHZ;

  typedef struct packed {
    logic [1:0]  f;
    logic [3:0]  mask;
    logic [3:0]  idle;
    logic [3:0]  found;
    logic [11:0] dwell;
    logic        ok;
  } vec_t;

  // field, lane mask, idle pattern, probe result, expected quiet cycles, probe succeeds
  localparam vec_t VECS [7] = '{
    '{2'd3, 4'hF, 4'hE, 4'h1, 12'd81,  1'b1},
    '{2'd3, 4'h3, 4'h3, 4'h6, 12'd480, 1'b1},
    '{2'd1, 4'hF, 4'hF, 4'h0, 12'd480, 1'b0},
    '{2'd2, 4'hF, 4'h7, 4'h8, 12'd41,  1'b1},
    '{2'd1, 4'h1, 4'hE, 4'h0, 12'd21,  1'b0},
    '{2'd0, 4'h3, 4'hC, 4'h4, 12'd1,   1'b0},
    '{2'd3, 4'h1, 4'h0, 4'h1, 12'd81,  1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0] laneMask = 4'hF;
  logic [3:0] elecIdle = 4'hF;
  logic rxDetDone = 1'b0;
  logic [3:0] rxDetFound = '0;
  logic linkRestart = 1'b0;
  logic rxDetReq, quietActive, detComplete;
  logic [3:0] detLanes;

  int total = 0;
  int bad = 0;
  int nq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  linkdet_seq #(.LANES(4), .CLK_KHZ(KHZ)) i_linkdet_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .laneMask(laneMask), .elecIdle(elecIdle),
    .rxDetDone(rxDetDone), .rxDetFound(rxDetFound), .linkRestart(linkRestart),
    .rxDetReq(rxDetReq), .quietActive(quietActive), .detComplete(detComplete),
    .detLanes(detLanes)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeField(input logic [1:0] f);
    @(posedge clk); #1;
    regWrEn = 1'b1;
    regWrData = 32'hFFFF_FFF9 | (32'(f) << 1);
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (rxDetReq) break;
      if (quietActive) n++;
    end
  endtask

  task automatic respond(input logic [3:0] found);
    @(posedge clk); #1;
    rxDetDone = 1'b1;
    rxDetFound = found;
    @(posedge clk); #1;
    rxDetDone = 1'b0;
    rxDetFound = '0;
  endtask

  task automatic restart();
    @(posedge clk); #1;
    linkRestart = 1'b1;
    @(posedge clk); #1;
    linkRestart = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R8 quiet after reset", int'(quietActive), 1);
    chk("R8 no request after reset", int'(rxDetReq), 0);
    chk("R8 not complete after reset", int'(detComplete), 0);
    chk("R8 lanes clear after reset", int'(detLanes), 0);
    chk("R8 field clear after reset", int'(regRdData), 0);

    // bring the link to complete once
    elecIdle = 4'h0;
    measure(nq);
    respond(4'hF);
    @(negedge clk);
    chk("R9 first complete", int'(detComplete), 1);

    // table-driven rounds
    foreach (VECS[i]) begin
      writeField(VECS[i].f);
      laneMask = VECS[i].mask;
      elecIdle = VECS[i].idle;
      @(negedge clk);
      chk("R7 readback field only", int'(regRdData), int'({VECS[i].f, 1'b0}));
      restart();
      measure(nq);
      chk($sformatf("R1 R2 R3 R6 dwell vec%0d", i), nq, int'(VECS[i].dwell));
      respond(VECS[i].found);
      if (VECS[i].ok) begin
        @(negedge clk);
        chk($sformatf("R9 complete vec%0d", i), int'(detComplete), 1);
        chk($sformatf("R6 R9 lanes vec%0d", i), int'(detLanes),
            int'(VECS[i].found & VECS[i].mask));
      end else begin
        measure(nq);
        chk($sformatf("R5 retry dwell vec%0d", i), nq, int'(VECS[i].dwell));
        respond(VECS[i].mask);
        @(negedge clk);
        chk($sformatf("R5 complete after retry vec%0d", i), int'(detComplete), 1);
        chk($sformatf("R9 lanes after retry vec%0d", i), int'(detLanes), int'(VECS[i].mask));
      end
      repeat (5) @(negedge clk);
      chk($sformatf("R9 complete holds vec%0d", i), int'(detComplete), 1);
    end

    // R2: idle exit on quiet cycle 10 is held until the 2 ms dwell
    writeField(2'd3);
    laneMask = 4'hF;
    elecIdle = 4'hF;
    restart();
    nq = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (rxDetReq) break;
      if (quietActive) nq++;
      if (nq == 10) elecIdle = 4'hD;
    end
    chk("R2 early exit held off", nq, 2 * KHZ + 1);
    respond(4'h2);
    @(negedge clk);
    chk("R9 lanes after held exit", int'(detLanes), 2);

    // R1: idle exit after the dwell ends the wait on that cycle
    elecIdle = 4'hF;
    restart();
    nq = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (rxDetReq) break;
      if (quietActive) nq++;
      if (nq == 100) elecIdle = 4'hD;
    end
    chk("R1 late exit honoured", nq, 100);
    chk("R4 request seen", int'(rxDetReq), 1);
    @(negedge clk);
    chk("R4 request single cycle", int'(rxDetReq), 0);
    rxDetDone = 1'b1;
    rxDetFound = 4'h4;
    @(posedge clk); #1;
    rxDetDone = 1'b0;
    rxDetFound = '0;
    @(negedge clk);
    chk("R9 complete on late exit", int'(detComplete), 1);

    // R8: reset in the middle of a run
    @(posedge clk); #1 rstN = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    chk("R8 quiet after mid reset", int'(quietActive), 1);
    chk("R8 lanes cleared by mid reset", int'(detLanes), 0);
    chk("R8 field cleared by mid reset", int'(regRdData), 0);
    chk("R3 timeout uses full window", TMO, 480);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule